// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block turns a three-wire serial audio stream (bit clock, word-select clock and data) into parallel left and right samples in the system clock domain. The three serial lines are oversampled by the system clock through two-flop synchronizers. Edges of the bit clock are found from the synchronized copy, so the bit clock may stop between bursts without disturbing the receiver.

One receiver covers five framing styles. They differ in which word-select level marks the left channel, how many bit slots pass between a word-select event and the first data bit, and which bit-clock edge captures data. The configured word length is 16, 18 or 20 bits. Each word is placed left-aligned in a 20-bit twos-complement output with zeros below its LSB. Data bits past the configured length are dropped. Once the right word that follows a left word has been captured, both words appear together with a one-cycle valid strobe.

Top module: `stereo_serial_rx`

## Requirements
- R1: Format code 0 (also codes 5 to 7): data is captured on rising bit-clock edges. The word-select high half is the left channel. The bit captured on the first rising edge after a word-select change is the MSB.
- R2: Format code 1: data is captured on rising edges. The word-select low half is the left channel. The MSB is the bit captured on the second rising edge after a word-select change.
- R3: Format code 2: data is captured on rising edges. Word-select high is left. The word is always 16 bits. Its MSB is captured on the 17th rising edge after a word-select change, which right-aligns the word in a 32-slot half.
- R4: Format code 3: data is captured on falling edges. The MSB is the first bit captured with word-select low after a capture that saw it high. After reset, the first such pulse opens a left word and the pulses then alternate right, left and so on.
- R5: Format code 4: rising-edge capture with word-select high as left, with 16 slots per half. The 16-bit word fills the half exactly.
- R6: Width select 0, 1, 2 or 3 gives 16, 18, 20 or 20 bits. Codes 2 and 4 always use 16 bits. Each output word carries the received MSB in bit 19, and every bit below the word's LSB is zero.
- R7: Data bits that arrive after the configured number of bits in a channel half have no effect on the output words.
- R8: pairValid is high for exactly one cycle after a right word completes that follows a completed left word. leftWord and rightWord change only in the cycle where pairValid is high, and each completed left/right pair produces exactly one pulse.
- R9: Pauses of the bit clock of any length between or inside words do not change the captured values.
- R10: While rst is high and right after it, leftWord and rightWord are zero and pairValid is low.
- R11: fmtSel may change only while rst is high. A format loaded during reset governs the stream that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bclkIn | input | 1 | Serial bit clock, may be gated |
| lrclkIn | input | 1 | Word-select / frame clock |
| sdataIn | input | 1 | Serial data, MSB first |
| fmtSel | input | 3 | Framing style code (see R1 to R5) |
| widthSel | input | 2 | Word length code (see R6) |
| leftWord | output | 20 | Left sample, left-aligned twos complement |
| rightWord | output | 20 | Right sample, left-aligned twos complement |
| pairValid | output | 1 | One-cycle strobe when a new stereo pair is present |

## Verification
The assertions take for granted that the bit clock stays at each level for at least two system clocks, so two capture edges never fall in adjacent cycles. They also assume fmtSel moves only under reset. The stimulus holds every bit-clock phase for four system clocks and changes data and word-select half a bit away from the capture edge. It loads each new format while rst is high. Before each stream it sends two lead-in slots at the idle word-select level, so that the first real channel begins on a genuine word-select event.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    FMT_LEFT   = 3'd0,
    FMT_I2S    = 3'd1,
    FMT_RIGHT  = 3'd2,
    FMT_DSP    = 3'd3,
    FMT_PACKED = 3'd4
  } srx_fmt_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic commitL;
    logic commitR;
  } srx_strobe_t;
endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int MAX_W     = 20,
  parameter int SHORT_W   = 16,
  parameter int HALF_BITS = 32,
  localparam int CNT_W    = $clog2(2 * HALF_BITS),
  localparam int WCW      = $clog2(MAX_W + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bclkIn,
  input  logic           lrclkIn,
  input  logic           sdataIn,
  input  srx_fmt_e       fmtSel,
  input  logic [1:0]     widthSel,
  output srx_strobe_t    stb,
  output logic           bitOut,
  output logic [WCW-1:0] effW
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] bSync, lSync, dSync;
  logic       bPrev;
  logic       bNow, lrNow, isDsp, capture;

  always_ff @(posedge clk) begin
    if (rst) begin
      bSync <= '0;
      lSync <= '0;
      dSync <= '0;
      bPrev <= 1'b0;
    end else begin
      bSync <= {bSync[0], bclkIn};
      lSync <= {lSync[0], lrclkIn};
      dSync <= {dSync[0], sdataIn};
      bPrev <= bSync[1];
    end
  end

  assign bNow    = bSync[1];
  assign lrNow   = lSync[1];
  assign bitOut  = dSync[1];
  assign isDsp   = (fmtSel == FMT_DSP);
  assign capture = isDsp ? (bPrev & ~bNow) : (~bPrev & bNow);

  // word length and MSB delay per format
  logic [WCW-1:0]   wideW;
  logic [CNT_W-1:0] dly;
  assign wideW = WCW'(SHORT_W) + WCW'({widthSel, 1'b0});

  always_comb begin
    case (fmtSel)
      FMT_RIGHT, FMT_PACKED: effW = WCW'(SHORT_W);
      default:               effW = (wideW > WCW'(MAX_W)) ? WCW'(MAX_W) : wideW;
    endcase
    case (fmtSel)
      FMT_RIGHT: dly = CNT_W'(HALF_BITS - SHORT_W);
      FMT_I2S:   dly = CNT_W'(1);
      default:   dly = '0;
    endcase
  end

  // slot tracking
  logic             prevLr, leftCh, dspPhase;
  logic [CNT_W-1:0] cnt, idx;
  logic [CNT_W:0]   idxX, lastIdx;
  logic             startEv, newLeft, curLeft, inWord, isLast;

  assign startEv = isDsp ? (prevLr & ~lrNow) : (prevLr ^ lrNow);
  assign newLeft = isDsp ? ~dspPhase : (lrNow == (fmtSel != FMT_I2S));
  assign idx     = startEv ? '0 : ((cnt == CNT_MAX) ? cnt : cnt + 1'b1);
  assign curLeft = startEv ? newLeft : leftCh;
  assign idxX    = {1'b0, idx};
  assign lastIdx = {1'b0, dly} + (CNT_W+1)'(effW) - 1'b1;
  assign inWord  = (idxX >= {1'b0, dly}) && (idxX <= lastIdx);
  assign isLast  = (idxX == lastIdx);

  always_comb begin
    stb.load    = capture & (idx == dly);
    stb.shift   = capture & inWord;
    stb.commitL = capture & inWord & isLast & curLeft;
    stb.commitR = capture & inWord & isLast & ~curLeft;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLr   <= 1'b0;
      cnt      <= CNT_MAX;
      leftCh   <= 1'b1;
      dspPhase <= 1'b0;
    end else if (capture) begin
      prevLr <= lrNow;
      cnt    <= idx;
      if (startEv) begin
        leftCh <= newLeft;
        if (isDsp) dspPhase <= ~dspPhase;
      end
    end
  end

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(fmtSel)); // R11
  AST_CAPTURE_SPACED: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture); // R9
endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int MAX_W = 20,
  localparam int WCW  = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  srx_strobe_t      stb,
  input  logic             bitIn,
  input  logic [WCW-1:0]   effW,
  output logic [MAX_W-1:0] leftWord,
  output logic [MAX_W-1:0] rightWord,
  output logic             pairValid
);
  logic [MAX_W-1:0] shReg, shNext, aligned, leftHold;
  logic [WCW-1:0]   shiftAmt;
  logic             leftHave;

  assign shNext   = stb.load ? {{(MAX_W-1){1'b0}}, bitIn} : {shReg[MAX_W-2:0], bitIn};
  assign shiftAmt = WCW'(MAX_W) - effW;
  assign aligned  = shNext << shiftAmt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg     <= '0;
      leftHold  <= '0;
      leftHave  <= 1'b0;
      leftWord  <= '0;
      rightWord <= '0;
      pairValid <= 1'b0;
    end else begin
      pairValid <= 1'b0;
      if (stb.shift) shReg <= shNext;
      if (stb.commitL) begin
        leftHold <= aligned;
        leftHave <= 1'b1;
      end
      if (stb.commitR) begin
        leftHave <= 1'b0;
        if (leftHave) begin
          leftWord  <= leftHold;
          rightWord <= aligned;
          pairValid <= 1'b1;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    pairValid |=> !pairValid); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pairValid |-> ($stable(leftWord) && $stable(rightWord))); // R8
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import srx_pkg::*;
#(
  parameter int MAX_W     = 20,
  parameter int SHORT_W   = 16,
  parameter int HALF_BITS = 32,
  localparam int WCW      = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclkIn,
  input  logic             lrclkIn,
  input  logic             sdataIn,
  input  logic [2:0]       fmtSel,
  input  logic [1:0]       widthSel,
  output logic [MAX_W-1:0] leftWord,
  output logic [MAX_W-1:0] rightWord,
  output logic             pairValid
);
  srx_strobe_t    stb;
  logic           bitSync;
  logic [WCW-1:0] effW;

  srx_ctrl #(.MAX_W(MAX_W), .SHORT_W(SHORT_W), .HALF_BITS(HALF_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .fmtSel(srx_fmt_e'(fmtSel)), .widthSel(widthSel),
    .stb(stb), .bitOut(bitSync), .effW(effW)
  );

  srx_datapath #(.MAX_W(MAX_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .bitIn(bitSync), .effW(effW),
    .leftWord(leftWord), .rightWord(rightWord), .pairValid(pairValid)
  );
endmodule

// File: tb/tb_stereo_serial_rx.sv
`timescale 1ns/1ps
module tb_stereo_serial_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclkIn = 1'b0, lrclkIn = 1'b0, sdataIn = 1'b0;
  logic [2:0]  fmtSel = 3'd0;
  logic [1:0]  widthSel = 2'd0;
  logic [19:0] leftWord, rightWord;
  logic        pairValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit prevV = 0;
  logic [39:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  stereo_serial_rx dut (
    .clk(clk), .rst(rst), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .fmtSel(fmtSel), .widthSel(widthSel),
    .leftWord(leftWord), .rightWord(rightWord), .pairValid(pairValid)
  );

  function automatic logic [19:0] expWord(logic [23:0] tx, int w);
    logic [19:0] m;
    m = 20'hFFFFF << (20 - w);
    return tx[23:4] & m;
  endfunction

  task automatic check(bit ok, string tag, logic [39:0] act, logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst) begin
      if (pairValid) begin
        if (prevV) check(0, "R8 pulse wider than one cycle", 40'd1, 40'd0);
        if (expQ.size() == 0) check(0, "R8 unexpected pair", {leftWord, rightWord}, 40'd0);
        else begin
          logic [39:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({leftWord, rightWord} == e, t, {leftWord, rightWord}, e);
        end
      end
      prevV = pairValid;
    end else prevV = 0;
  end

  task automatic bitSlot(logic lrv, logic dv, bit fallCap, int stall);
    @(negedge clk);
    lrclkIn = lrv;
    sdataIn = dv;
    repeat (stall + 4) @(negedge clk);
    bclkIn = fallCap ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    bclkIn = fallCap ? 1'b1 : 1'b0;
  endtask

  task automatic doReset(int fmt, int wcode);
    @(negedge clk);
    rst = 1'b1;
    fmtSel = 3'(fmt);
    widthSel = 2'(wcode);
    bclkIn = (fmt == 3);
    lrclkIn = (fmt == 1);
    sdataIn = 1'b0;
    repeat (5) @(negedge clk);
    check(leftWord == 0 && rightWord == 0 && pairValid == 0, "R10 reset state",
          {leftWord, rightWord}, 40'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(leftWord == 0 && rightWord == 0 && pairValid == 0, "R10 after release",
          {leftWord, rightWord}, 40'd0);
    for (int i = 0; i < 2; i++) bitSlot(fmt == 1, 1'b1, fmt == 3, 0);
  endtask

  task automatic sendHalf(int fmt, bit isLeft, int sendLen, logic [23:0] tx, int stallAt);
    logic lv;
    case (fmt)
      1: begin
        lv = isLeft ? 1'b0 : 1'b1;
        for (int i = 0; i < 32; i++)
          bitSlot(lv, (i >= 1 && i <= sendLen) ? tx[24 - i] : 1'b1, 0, (i == stallAt) ? 150 : 0);
      end
      2: begin
        lv = isLeft;
        for (int i = 0; i < 32; i++)
          bitSlot(lv, (i >= 16) ? tx[23 - (i - 16)] : 1'b1, 0, 0);
      end
      3: begin
        bitSlot(1'b1, 1'b1, 1, 0);
        for (int k = 0; k < sendLen; k++) bitSlot(1'b0, tx[23 - k], 1, (k == stallAt) ? 150 : 0);
        bitSlot(1'b0, 1'b1, 1, 0);
      end
      default: begin
        lv = isLeft;
        for (int i = 0; i < ((fmt == 4) ? 16 : 32); i++)
          bitSlot(lv, (i < sendLen) ? tx[23 - i] : 1'b1, 0, (i == stallAt) ? 150 : 0);
      end
    endcase
  endtask

  task automatic sendFrame(int fmt, int sendLen, int w, logic [23:0] txL, logic [23:0] txR,
                           int stallAt, string tag);
    expQ.push_back({expWord(txL, w), expWord(txR, w)});
    tagQ.push_back(tag);
    sendHalf(fmt, 1, sendLen, txL, stallAt);
    sendHalf(fmt, 0, sendLen, txR, -1);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(leftWord == 0 && rightWord == 0 && pairValid == 0, "R10 initial reset",
          {leftWord, rightWord}, 40'd0);

    // left-justified, 16/18/20 bits, extra bits, bursty bit clock
    doReset(0, 0);
    sendFrame(0, 16, 16, 24'hA5C300, 24'h3C5A00, -1, "R1 left-justified 16");
    sendFrame(0, 24, 16, 24'h8001FF, 24'h7FFEFF, -1, "R7 extra bits ignored");
    repeat (300) @(negedge clk);
    sendFrame(0, 16, 16, 24'h123400, 24'hFEDC00, 7, "R9 stalled bit clock");
    doReset(0, 1);
    sendFrame(0, 18, 18, 24'hDEADBE, 24'h2468AC, -1, "R6 width 18");
    doReset(0, 2);
    sendFrame(0, 20, 20, 24'h9ABCDE, 24'h13579B, -1, "R6 width 20");
    sendFrame(0, 24, 20, 24'h7FFFFF, 24'h800000, -1, "R7 width 20 extra bits");
    doReset(6, 0);
    sendFrame(0, 16, 16, 24'h0F0F00, 24'hF0F000, -1, "R1 unused code acts left-justified");

    // I2S-style
    doReset(1, 1);
    sendFrame(1, 18, 18, 24'hC0FFEE, 24'h31415A, -1, "R2 delayed MSB 18");
    sendFrame(1, 20, 18, 24'h55AA33, 24'hAA55CC, 5, "R2 R7 stall and extra bits");

    // right-justified, width forced to 16
    doReset(2, 2);
    sendFrame(2, 16, 16, 24'hBEEF00, 24'h0A0B00, -1, "R3 right-justified");
    sendFrame(2, 16, 16, 24'h800000, 24'h7FFF00, -1, "R3 R6 extremes");

    // pulse-framed, falling capture
    doReset(3, 0);
    sendFrame(3, 16, 16, 24'h600D00, 24'hF00D00, -1, "R4 pulse framing 16");
    sendFrame(3, 16, 16, 24'h1111FF, 24'hEEEE00, 4, "R4 R9 second pair with stall");
    doReset(3, 2);
    sendFrame(3, 20, 20, 24'hABCDEF, 24'h987654, -1, "R4 R11 pulse framing 20");

    // packed, width forced to 16
    doReset(4, 2);
    sendFrame(4, 16, 16, 24'hCAFE00, 24'h4321FF, -1, "R5 packed");
    sendFrame(4, 16, 16, 24'h000100, 24'hFFFF00, -1, "R5 R6 packed edge values");

    repeat (50) @(negedge clk);
    check(expQ.size() == 0, "R8 every pair produced one strobe", 40'(expQ.size()), 40'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule